// File: doc/BRIEF.md
# Flash Access-Control Key Guard

This block protects a flash access-control register so that it cannot be written by mistake. After reset the register is closed to writes. Software opens it by writing a fixed first key word to one key address and then a fixed second key word to another key address. The guard then raises an unlocked flag and accepts writes to the protected register. When the flash controller reports that an operation has finished, the register is closed again. The same key pair must therefore be written again before software can clear the enable and control bits at the end of an operation.

A wrong key word, or a second key written without a valid first key in front of it, sets a sticky lockout. The lockout holds until the next reset. While it is set, no key sequence can open the register. The reset input is asynchronous and active-low. It is released through a synchronizer, so the logic starts to work two clock edges after the reset input goes high.

Top module: `flash_key_guard`

## Requirements
- R1: After reset, `unlocked` is 0 and `acc_value` is all zeros.
- R2: A write of 0x52537175 to the first key address (0x8), followed by a write of 0xA91875FC to the second key address (0xC), sets `unlocked` to 1. The flag is visible after the clock edge that takes the second key write.
- R3: While `unlocked` is 0, writes to the protected register address (0x0) are dropped, and `acc_value` keeps its value.
- R4: Any of these sets the lockout: a value other than 0x52537175 written to the first key address; a value other than 0xA91875FC written to the second key address; a write to the second key address when no correct first key is pending. Setting the lockout also clears `unlocked`.
- R5: Once the lockout is set, only reset clears it. While it is set, even a correct key pair leaves `unlocked` at 0.
- R6: A cycle with `op_done` high sets `unlocked` to 0 on the next edge and discards any pending first key.
- R7: While `unlocked` is 1, a write to address 0x0 stores the low `ACC_W` bits of `wr_data` into `acc_value` on the next edge. This also holds when `op_done` is high in the same cycle.
- R8: A pending correct first key survives writes to other addresses, including dropped writes to the protected register. A later correct second key still unlocks.
- R9: A key write while `unlocked` is 1 closes the register. A correct first key leaves it pending, so a correct second key alone opens it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | DATA_W (32) | Register write data |
| op_done | input | 1 | Flash operation finished pulse |
| unlocked | output | 1 | Protected register accepts writes |
| acc_value | output | ACC_W (16) | Stored access-control value |

## Verification
Every result of this block is due exactly one clock edge after the write or `op_done` cycle that causes it. This covers the unlocked flag, the stored value and the lockout. The lockout shows up at the ports when a later correct key pair fails to open the register.

The bench drives inputs on falling edges. A behavioural model updates on the rising edge, and both outputs are compared with the model on the following falling edge. That sample lands one edge after the stimulus, so every check reads an output in the cycle it becomes due.

After each reset the bench waits idle cycles to cover the two-edge synchronizer delay before it sends any stimulus.

// File: rtl/fkg_pkg.sv
package fkg_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED  = 2'd0,
    ST_PENDING = 2'd1,
    ST_OPEN    = 2'd2
  } guard_state_e;

  localparam logic [31:0] KEY_FIRST_DEF  = 32'h5253_7175;
  localparam logic [31:0] KEY_SECOND_DEF = 32'hA918_75FC;
endpackage

// File: rtl/fkg_rst_sync.sv
module fkg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/fkg_addr_dec.sv
module fkg_addr_dec #(
  parameter int          ADDR_W     = 4,
  parameter int          DATA_W     = 32,
  parameter logic [ADDR_W-1:0] ACC_ADDR   = 4'h0,
  parameter logic [ADDR_W-1:0] KEY0_ADDR  = 4'h8,
  parameter logic [ADDR_W-1:0] KEY1_ADDR  = 4'hC,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h5253_7175,
  parameter logic [DATA_W-1:0] KEY_SECOND = 32'hA918_75FC
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hit_acc_o,
  output logic              hit_k0_o,
  output logic              hit_k1_o,
  output logic              k0_ok_o,
  output logic              k1_ok_o
);
  always_comb begin
    hit_acc_o = wr_en_i && (wr_addr_i == ACC_ADDR);
    hit_k0_o  = wr_en_i && (wr_addr_i == KEY0_ADDR);
    hit_k1_o  = wr_en_i && (wr_addr_i == KEY1_ADDR);
    k0_ok_o   = (wr_data_i == KEY_FIRST);
    k1_ok_o   = (wr_data_i == KEY_SECOND);
  end
endmodule

// File: rtl/fkg_key_fsm.sv
module fkg_key_fsm
  import fkg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_k0_i,
  input  logic hit_k1_i,
  input  logic k0_ok_i,
  input  logic k1_ok_i,
  input  logic op_done_i,
  output logic open_o
);
  guard_state_e state_q, state_d;
  logic         lock_q, lock_d;
  logic         bad_seq;
  logic         state_en, lock_en;

  always_comb begin
    state_d = state_q;
    lock_d  = lock_q;
    bad_seq = 1'b0;
    if (!lock_q) begin
      if (hit_k0_i) begin
        if (k0_ok_i) state_d = ST_PENDING;
        else         bad_seq = 1'b1;
      end else if (hit_k1_i) begin
        if (state_q == ST_PENDING && k1_ok_i) state_d = ST_OPEN;
        else                                  bad_seq = 1'b1;
      end
    end
    if (bad_seq) begin
      lock_d  = 1'b1;
      state_d = ST_LOCKED;
    end
    if (op_done_i) state_d = ST_LOCKED;
  end

  assign state_en = (state_d != state_q);
  assign lock_en  = (lock_d != lock_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_LOCKED;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign open_o = (state_q == ST_OPEN);

  // R2: opening only follows an accepted second key with the first pending
  assert_open_needs_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(hit_k1_i && k1_ok_i && state_q == ST_PENDING));

  // R4: a wrong first key latches the lockout
  assert_bad_key0_locks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_k0_i && !k0_ok_i) |=> lock_q);

  // R4: second key without a pending first key latches the lockout
  assert_early_key1_locks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_k1_i && state_q != ST_PENDING) |=> lock_q);

  // R5: lockout is sticky and keeps the register closed
  assert_lockout_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> (lock_q && !open_o));

  // R6: operation completion closes the register
  assert_done_relocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i |=> !open_o);
endmodule

// File: rtl/fkg_acc_reg.sv
module fkg_acc_reg #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             we_i,
  input  logic [ACC_W-1:0] data_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;

  always_comb begin
    acc_en = open_i && we_i;
    acc_d  = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R3: closed register never changes
  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(acc_q));

  // R7: open write lands one edge later
  assert_open_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && we_i) |=> (acc_q == $past(data_i)));
endmodule

// File: rtl/flash_key_guard.sv
module flash_key_guard
  import fkg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int ACC_W  = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 4'h0,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 4'h8,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 4'hC,
  parameter logic [DATA_W-1:0] KEY_FIRST  = KEY_FIRST_DEF,
  parameter logic [DATA_W-1:0] KEY_SECOND = KEY_SECOND_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic              unlocked,
  output logic [ACC_W-1:0]  acc_value
);
  logic rst_int_n;
  logic hit_acc, hit_k0, hit_k1, k0_ok, k1_ok;
  logic open_w;

  fkg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i (clk),
    .rst_ni(rst_n),
    .rst_no(rst_int_n)
  );

  fkg_addr_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ACC_ADDR(ACC_ADDR), .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_dec (
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .hit_acc_o(hit_acc),
    .hit_k0_o (hit_k0),
    .hit_k1_o (hit_k1),
    .k0_ok_o  (k0_ok),
    .k1_ok_o  (k1_ok)
  );

  fkg_key_fsm u_fsm (
    .clk_i    (clk),
    .rst_ni   (rst_int_n),
    .hit_k0_i (hit_k0),
    .hit_k1_i (hit_k1),
    .k0_ok_i  (k0_ok),
    .k1_ok_i  (k1_ok),
    .op_done_i(op_done),
    .open_o   (open_w)
  );

  fkg_acc_reg #(.ACC_W(ACC_W)) u_acc (
    .clk_i (clk),
    .rst_ni(rst_int_n),
    .open_i(open_w),
    .we_i  (hit_acc),
    .data_i(wr_data[ACC_W-1:0]),
    .acc_o (acc_value)
  );

  assign unlocked = open_w;
endmodule

// File: tb/flash_key_guard_tb.sv
`timescale 1ns/1ps
module flash_key_guard_tb;
  localparam logic [3:0]  A_ACC = 4'h0, A_K0 = 4'h8, A_K1 = 4'hC, A_OTHER = 4'h4;
  localparam logic [31:0] K0 = 32'h5253_7175, K1 = 32'hA918_75FC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic        unlocked;
  logic [15:0] acc_value;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference: 0 closed, 1 first key pending, 2 open
  int          m_state = 0;
  bit          m_lock = 1'b0;
  logic [15:0] m_acc = '0;

  always #4 clk = ~clk;

  flash_key_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .unlocked(unlocked),
    .acc_value(acc_value)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_lock = 1'b0; m_acc = '0;
    end else begin
      int  nxt;
      bit  bad;
      nxt = m_state;
      bad = 1'b0;
      if (wr_en && wr_addr == A_ACC && m_state == 2) m_acc = wr_data[15:0];
      if (wr_en && !m_lock) begin
        if (wr_addr == A_K0) begin
          if (wr_data == K0) nxt = 1; else bad = 1'b1;
        end else if (wr_addr == A_K1) begin
          if (m_state == 1 && wr_data == K1) nxt = 2; else bad = 1'b1;
        end
      end
      if (bad) begin m_lock = 1'b1; nxt = 0; end
      if (op_done) nxt = 0;
      m_state = nxt;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, one edge after stimulus
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, {31'd0, unlocked}, {31'd0, (m_state == 2)});
      chk(cur_req, {16'd0, acc_value}, {16'd0, m_acc});
    end
  end

  task automatic put(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    wr_en = 1'b0; op_done = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; op_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    cur_req = "R1";
    chk("R1", {31'd0, unlocked}, 32'd0);
    chk("R1", {16'd0, acc_value}, 32'd0);

    cur_req = "R3";
    put(A_ACC, 32'h0000_BEEF); idle(1);
    chk("R3", {16'd0, acc_value}, 32'd0);

    cur_req = "R2";
    put(A_K0, K0);
    chk("R2", {31'd0, unlocked}, 32'd0);
    put(A_K1, K1);
    chk("R2", {31'd0, unlocked}, 32'd1);

    cur_req = "R7";
    put(A_ACC, 32'hFFFF_1234);
    chk("R7", {16'd0, acc_value}, 32'h1234);

    cur_req = "R6";
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    chk("R6", {31'd0, unlocked}, 32'd0);
    put(A_ACC, 32'h0000_5555);
    chk("R6", {16'd0, acc_value}, 32'h1234);
    put(A_K0, K0);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    put(A_K1, K1); idle(1);
    chk("R6", {31'd0, unlocked}, 32'd0);
    do_reset();

    cur_req = "R8";
    put(A_K0, K0);
    put(A_ACC, 32'h0000_7777);
    put(A_OTHER, 32'h0);
    put(A_K1, K1);
    chk("R8", {31'd0, unlocked}, 32'd1);
    chk("R8", {16'd0, acc_value}, 32'd0);

    cur_req = "R9";
    put(A_K0, K0);
    chk("R9", {31'd0, unlocked}, 32'd0);
    put(A_K1, K1);
    chk("R9", {31'd0, unlocked}, 32'd1);

    cur_req = "R7";
    wr_en = 1'b1; wr_addr = A_ACC; wr_data = 32'h0000_0000; op_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; op_done = 1'b0;
    chk("R7", {16'd0, acc_value}, 32'h0);
    chk("R7", {31'd0, unlocked}, 32'd0);

    cur_req = "R4";
    put(A_K1, K1); idle(1);
    chk("R4", {31'd0, unlocked}, 32'd0);
    cur_req = "R5";
    put(A_K0, K0); put(A_K1, K1); idle(1);
    chk("R5", {31'd0, unlocked}, 32'd0);
    put(A_ACC, 32'h0000_ABCD);
    chk("R5", {16'd0, acc_value}, 32'h0);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    put(A_K0, K0); put(A_K1, K1); idle(1);
    chk("R5", {31'd0, unlocked}, 32'd0);

    do_reset();
    cur_req = "R4";
    put(A_K0, K0 ^ 32'h1);
    put(A_K0, K0); put(A_K1, K1); idle(1);
    chk("R4", {31'd0, unlocked}, 32'd0);

    do_reset();
    put(A_K0, K0); put(A_K1, K1 ^ 32'h8000_0000);
    put(A_K0, K0); put(A_K1, K1); idle(1);
    chk("R4", {31'd0, unlocked}, 32'd0);

    do_reset();
    cur_req = "R5";
    put(A_K0, K0); put(A_K1, K1);
    chk("R5", {31'd0, unlocked}, 32'd1);
    put(A_ACC, 32'h0000_00A5);
    chk("R5", {16'd0, acc_value}, 32'h00A5);

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule